// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one memory burst. A burst request carries a start column, a length code and an ordering choice (sequential wrap or interleaved). From the cycle after the request, the block presents one column per clock together with a valid flag. A last-beat flag marks the final column of a fixed-length burst, and an error flag marks a request whose ordering and length cannot be combined.

A running burst can be stopped at any cycle with a terminate input, or discarded and replaced at any cycle by a new request. The replacement sequence begins at once. A full-page burst covers all 256 columns, wraps from the top column back to zero, and runs until it is stopped or replaced. Data, banks, rows and command pins are handled elsewhere.

Top module: `burst_colgen`

## Requirements
- R1: After reset, and until the first request, `valid`, `last` and `mode_err` are 0.
- R2: When `start` is 1 at a rising edge, `valid` is 1 in the following cycle and `col` equals the `start_col` that was sampled (beat 0).
- R3: `len_code` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats; any value from 4 to 7 selects a full-page burst. A fixed-length burst shows exactly that many valid beats, one per cycle, and `valid` is 0 in the cycle after the final beat unless a new request was sampled.
- R4: With `interleave` = 0 and BL beats, beat n shows the upper bits of `start_col` unchanged and the low log2(BL) bits equal to (low bits of `start_col` + n) modulo BL.
- R5: With `interleave` = 1 and a fixed length BL, beat n shows `start_col` XOR n, where n is below BL.
- R6: A full-page burst shows (`start_col` + n) modulo 256 on beat n, wraps from 255 to 0, and stays valid until terminated or replaced.
- R7: `last` is 1 exactly on beat BL-1 of a fixed-length burst and is never 1 during a full-page burst or while `valid` is 0.
- R8: When `term` is 1 and `start` is 0 at a rising edge during a burst, `valid` is 0 in the following cycle; `term` while no burst runs leaves `valid` at 0.
- R9: A request sampled during a running burst discards it and the new sequence starts with beat 0 in the next cycle; when `start` and `term` are both 1 at the same edge, the request wins.
- R10: A request with `interleave` = 1 and a full-page length runs as a sequential full-page burst, and `mode_err` is 1 on every beat of that burst and 0 on all other bursts.
- R11: A burst of length 1 shows one valid beat at `start_col` with `last` = 1 on that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request, begins a new burst |
| start_col | input | 8 | First column of the requested burst |
| len_code | input | 3 | Length select: 0..3 give 2^code beats, 4..7 give full page |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential order |
| term | input | 1 | Stops the running burst |
| col | output | 8 | Current column |
| valid | output | 1 | `col` holds a beat of a burst |
| last | output | 1 | Current beat is the final one of a fixed-length burst |
| mode_err | output | 1 | Current burst asked for interleaved full page |

## Verification
The assertions take for granted that `start_col`, `len_code` and `interleave` matter only in a cycle where `start` is 1, and that every input is stable around the rising edge. Every length code is legal, so no input combination is excluded. The stimulus changes inputs only on the falling edge, and it holds the request fields together with `start`. Directed bursts cover each length and order, wraps and collisions of start with terminate, and a long random mix of requests and terminations follows them.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  // Highest length code that still selects a fixed power-of-two burst.
  localparam int unsigned MAX_FIXED_CODE = 3;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic [LEN_W-1:0]  len_code,
  input  logic              interleave,
  output logic [COL_W-1:0]  mask,
  output logic              full,
  output colgen_pkg::order_e order,
  output logic              err
);
  import colgen_pkg::*;

  localparam int unsigned FULL_CODE = MAX_FIXED_CODE + 1;

  assign full = (32'(len_code) >= FULL_CODE);

  // Bit i of the wrap mask is set when the burst spans more than 2^i columns.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask[i] = full | (32'(len_code) > i);
  end

  // Interleaved full page is not a legal pairing: fall back to sequential.
  assign order = (interleave && !full) ? ORD_ILV : ORD_SEQ;
  assign err   = interleave & full;

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0]   base,
  input  logic [COL_W-1:0]   beat,
  input  logic [COL_W-1:0]   mask,
  input  colgen_pkg::order_e order,
  output logic [COL_W-1:0]   addr
);
  import colgen_pkg::*;

  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] seq_addr;
  logic [COL_W-1:0] ilv_addr;

  always_comb begin
    seq_low  = (base + beat) & mask;
    seq_addr = (base & ~mask) | seq_low;
    ilv_addr = base ^ (beat & mask);
    addr     = (order == ORD_ILV) ? ilv_addr : seq_addr;
  end

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
  parameter int unsigned COL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               term,
  input  logic [COL_W-1:0]   req_base,
  input  logic [COL_W-1:0]   req_mask,
  input  logic               req_full,
  input  colgen_pkg::order_e req_order,
  input  logic               req_err,
  output logic               nxt_act,
  output logic [COL_W-1:0]   nxt_beat,
  output logic [COL_W-1:0]   nxt_base,
  output logic [COL_W-1:0]   nxt_mask,
  output logic               nxt_full,
  output colgen_pkg::order_e nxt_order,
  output logic               nxt_err,
  output logic               cur_act,
  output logic               cur_full
);
  import colgen_pkg::*;

  logic             act_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  order_e           order_q;
  logic             err_q;
  logic             at_end;

  assign at_end = !full_q && (beat_q == mask_q);

  always_comb begin
    nxt_act   = act_q;
    nxt_beat  = beat_q;
    nxt_base  = base_q;
    nxt_mask  = mask_q;
    nxt_full  = full_q;
    nxt_order = order_q;
    nxt_err   = err_q;
    if (start) begin
      nxt_act   = 1'b1;
      nxt_beat  = '0;
      nxt_base  = req_base;
      nxt_mask  = req_mask;
      nxt_full  = req_full;
      nxt_order = req_order;
      nxt_err   = req_err;
    end else if (act_q) begin
      if (term || at_end) begin
        nxt_act = 1'b0;
      end else begin
        nxt_beat = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      order_q <= ORD_SEQ;
      err_q   <= 1'b0;
    end else begin
      act_q   <= nxt_act;
      beat_q  <= nxt_beat;
      base_q  <= nxt_base;
      mask_q  <= nxt_mask;
      full_q  <= nxt_full;
      order_q <= nxt_order;
      err_q   <= nxt_err;
    end
  end

  assign cur_act  = act_q;
  assign cur_full = full_q;

  // R3: a fixed burst never counts beyond its wrap mask
  a_r3_beat_in_range: assert property (@(posedge clk) disable iff (rst)
    act_q && !full_q |-> (beat_q & ~mask_q) == '0);

  // R10: only a full-page burst can carry the error marker
  a_r10_err_needs_full: assert property (@(posedge clk) disable iff (rst)
    act_q && err_q |-> full_q);

  // R6: a full-page burst keeps running without stop or restart
  a_r6_full_runs_on: assert property (@(posedge clk) disable iff (rst)
    act_q && full_q && !start && !term |=> act_q);

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_code,
  input  logic             interleave,
  input  logic             term,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             mode_err
);
  import colgen_pkg::*;

  logic [COL_W-1:0] req_mask;
  logic             req_full;
  order_e           req_order;
  logic             req_err;

  logic             nxt_act;
  logic [COL_W-1:0] nxt_beat;
  logic [COL_W-1:0] nxt_base;
  logic [COL_W-1:0] nxt_mask;
  logic             nxt_full;
  order_e           nxt_order;
  logic             nxt_err;
  logic             cur_act;
  logic             cur_full;
  logic [COL_W-1:0] nxt_addr;
  logic             nxt_last;

  colgen_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W)) u_dec (
    .len_code   (len_code),
    .interleave (interleave),
    .mask       (req_mask),
    .full       (req_full),
    .order      (req_order),
    .err        (req_err)
  );

  colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .term      (term),
    .req_base  (start_col),
    .req_mask  (req_mask),
    .req_full  (req_full),
    .req_order (req_order),
    .req_err   (req_err),
    .nxt_act   (nxt_act),
    .nxt_beat  (nxt_beat),
    .nxt_base  (nxt_base),
    .nxt_mask  (nxt_mask),
    .nxt_full  (nxt_full),
    .nxt_order (nxt_order),
    .nxt_err   (nxt_err),
    .cur_act   (cur_act),
    .cur_full  (cur_full)
  );

  colgen_addr_calc #(.COL_W(COL_W)) u_addr (
    .base  (nxt_base),
    .beat  (nxt_beat),
    .mask  (nxt_mask),
    .order (nxt_order),
    .addr  (nxt_addr)
  );

  assign nxt_last = nxt_act && !nxt_full && (nxt_beat == nxt_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      valid    <= 1'b0;
      last     <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      col      <= nxt_addr;
      valid    <= nxt_act;
      last     <= nxt_last;
      mode_err <= nxt_act & nxt_err;
    end
  end

  // R2: a request shows its start column on the next cycle
  a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
    start |=> valid && (col == $past(start_col)));

  // R3: after the final beat the burst ends unless restarted
  a_r3_end_after_last: assert property (@(posedge clk) disable iff (rst)
    valid && last && !start |=> !valid);

  // R7: last only accompanies a valid beat of a fixed burst
  a_r7_last_valid: assert property (@(posedge clk) disable iff (rst)
    last |-> valid && !cur_full);

  // R8: terminate without a request ends the burst
  a_r8_term_stops: assert property (@(posedge clk) disable iff (rst)
    valid && term && !start |=> !valid);

  // R9: a non-final beat with no stop or restart is followed by another beat
  a_r9_continues: assert property (@(posedge clk) disable iff (rst)
    valid && !last && !start && !term |=> valid);

  // R10: the error flag only appears on a valid beat
  a_r10_err_valid: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> valid);

  // R1: output valid follows the internal burst state
  a_r1_valid_state: assert property (@(posedge clk) disable iff (rst)
    valid == cur_act);

endmodule

// File: tb/tb_burst_colgen.sv
module tb_burst_colgen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0;
  logic       term = 1'b0;
  logic [7:0] col;
  logic       valid;
  logic       last;
  logic       mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1 reset";

  // reference model state
  int m_act = 0;
  int m_n = 0;
  int m_bl = 1;
  int m_start = 0;
  int m_ilv = 0;
  int m_full = 0;
  int m_err = 0;

  always #5 clk = ~clk;

  burst_colgen dut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .term(term),
    .col(col), .valid(valid), .last(last), .mode_err(mode_err)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0;
    end else if (start) begin
      m_act   = 1;
      m_n     = 0;
      m_start = int'(start_col);
      m_full  = (len_code >= 3'd4) ? 1 : 0;
      m_bl    = m_full ? 256 : (1 << len_code);
      m_ilv   = (interleave && !m_full) ? 1 : 0;
      m_err   = (interleave && m_full) ? 1 : 0;
    end else if (m_act != 0) begin
      if (term) m_act = 0;
      else if (!m_full && m_n == m_bl - 1) m_act = 0;
      else m_n = (m_n + 1) % 256;
    end
  end

  function automatic int exp_col();
    int blk;
    blk = m_start - (m_start % m_bl);
    if (m_ilv != 0) return m_start ^ m_n;
    return blk + ((m_start % m_bl) + m_n) % m_bl;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h exp %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("valid", int'(valid), m_act);
    if (m_act != 0) begin
      chk("col", int'(col), exp_col());
      chk("last (R7)", int'(last),
          (!m_full && m_n == m_bl - 1) ? 1 : 0);
      chk("mode_err (R10)", int'(mode_err), m_err);
    end else begin
      chk("last idle (R7)", int'(last), 0);
      chk("mode_err idle (R10)", int'(mode_err), 0);
    end
  endtask

  // one cycle: drive at falling edge, compare at the next falling edge
  task automatic cyc(input bit s, input int c, input int l, input bit il, input bit t);
    start = s; start_col = 8'(c); len_code = 3'(l); interleave = il; term = t;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1 reset";
    chk("valid", int'(valid), 0);
    chk("last", int'(last), 0);
    chk("mode_err", int'(mode_err), 0);
    cur_req = "R8 term while idle";
    cyc(0, 0, 0, 0, 1);
    idle(1);

    cur_req = "R2 R4 sequential 8 from 35";
    cyc(1, 'h35, 3, 0, 0);
    chk("R2 first col", int'(col), 'h35);
    idle(9);

    cur_req = "R5 interleaved 4 from 0E";
    cyc(1, 'h0E, 2, 1, 0);
    idle(5);
    cur_req = "R5 interleaved 8 from 93";
    cyc(1, 'h93, 3, 1, 0);
    idle(9);
    cur_req = "R4 sequential 2 from 7F";
    cyc(1, 'h7F, 1, 0, 0);
    idle(3);

    cur_req = "R11 single beat";
    cyc(1, 'hC6, 0, 0, 0);
    chk("R11 last", int'(last), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R11 ends", int'(valid), 0);
    cyc(1, 'h21, 0, 1, 0);
    idle(2);

    cur_req = "R6 full page wrap from FA";
    cyc(1, 'hFA, 7, 0, 0);
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 0, 0);
    cur_req = "R8 term full page";
    cyc(0, 0, 0, 0, 1);
    chk("R8 stopped", int'(valid), 0);
    idle(2);

    cur_req = "R10 interleaved full page";
    cyc(1, 'h13, 4, 1, 0);
    chk("R10 err", int'(mode_err), 1);
    idle(20);
    cur_req = "R10 next burst clears err";
    cyc(1, 'h40, 5, 0, 0);
    chk("R10 err clear", int'(mode_err), 0);
    idle(3);

    cur_req = "R9 restart mid-burst";
    cyc(1, 'h10, 3, 0, 0);
    idle(3);
    cyc(1, 'hA5, 2, 1, 0);
    chk("R9 restart col", int'(col), 'hA5);
    idle(2);
    cur_req = "R9 start beats term";
    cyc(1, 'h66, 3, 0, 1);
    chk("R9 start wins", int'(valid), 1);
    idle(2);
    cur_req = "R8 term mid fixed burst";
    cyc(0, 0, 0, 0, 1);
    idle(3);

    cur_req = "R3 R9 random mix";
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 6) == 0, int'($urandom % 256), int'($urandom % 8),
          ($urandom % 2) == 1, ($urandom % 25) == 0);
    end
    idle(300);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule